// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the command line of an SD/MMC card bus. Software writes a 32-bit argument, then writes a send word that carries the command byte, the response length and a few mode flags. That second write starts the engine. The engine shifts out a 48-bit command frame that ends in a CRC7 and a stop bit. It can then capture the card's response, which is either a short frame (48 bits) or a long one (136 bits), and check the response CRC7. If asked, it also waits for the card to release DAT0 before it reports completion.

Completion is reported through a done flag, which can raise an interrupt, and through status bits for CRC success, CRC failure and response timeout. The captured response is read as 32-bit words through the argument address. A read index selects the first word and moves to the next word on each read. Each register-bus cycle is one bit on the command line; dividing the card clock and handling the data lines are left to other blocks.

Top module: `sd_cmd_engine`

Register map (`wr_addr`/`rd_addr`):

| Address | Write | Read |
|---|---|---|
| 0 | command argument | response word at the read index |
| 1 | send word (starts a command) | send word |
| 2 | status, write 1 to bit 4 to clear done | status |
| 3 | control | control |

Send word fields:

| Bits | Meaning |
|---|---|
| [7:0] | command byte |
| [15:8] | response bit count |
| 16 | response expected |
| 17 | CRC check off |
| 18 | long-response CRC mode |
| 19 | busy wait on DAT0 |

Status bits:

| Bit | Meaning |
|---|---|
| 0 | engine active |
| 1 | CRC matched |
| 2 | CRC error |
| 3 | timeout |
| 4 | done |

Control bits:

| Bits | Meaning |
|---|---|
| 0 | interrupt enable |
| 1 | abort (write 1) |
| [9:8] | response read index |

## Requirements
- R1: A write to address 1 while the engine is idle starts a command. `cmd_oe` is high for exactly 48 cycles, starting the cycle after the write. During those cycles `cmd_out` carries, in order:
  - the command byte, MSB first;
  - the argument, MSB first;
  - a 7-bit CRC over those 40 bits, using x^7+x^3+1 with a zero start value;
  - a 1.
- R2: The response bit count in send bits [15:8] equals the number of bits between the start bit and the end bit, minus one: 45 for a short response and 133 for a long one. When send bit 16 is set, the engine waits for a 0 start bit on `cmd_in`, then samples count+1 payload bits, then one end bit.
- R3: Reading address 0 returns response word k, where k is the read index. The index is written through control bits [9:8] and advances by one after each read of address 0. Word k holds payload bits [7+32k +: 32], counting from the last payload bit as bit 0:
  - for a short response, word 0 is the 32 bits between the 7-bit header and the CRC;
  - a long response yields four words, and word 3 is the most significant.
- R4: Status bit 1 is set when the received CRC matches a CRC7 computed over the payload bits before it, and the end bit is 1. When send bit 18 is set, the first 7 payload bits are left out of that CRC.
- R5: When a response CRC does not match, status bit 2 is set. If send bit 17 is set, status bit 2 stays clear whatever the CRC.
- R6: When send bit 19 is set, done is withheld after the frame ends for as long as `dat0_in` is low. Done is set on the first edge at which `dat0_in` is high.
- R7: If no start bit is seen within 64 cycles of waiting, status bits 3 and 4 are set and the engine goes idle.
- R8: Status bit 4 (done) is cleared by writing 1 to it. `irq` equals done AND control bit 0.
- R9: Writing 1 to control bit 1 aborts the engine on the next edge. Afterwards `cmd_oe` is 0 and status bits 0 to 4 are 0.
- R10: Status bit 0 is 1 while a command is in progress. A write to address 1 during that time is ignored, and the send word reads back unchanged.
- R11: After reset, `cmd_oe` is 0, `cmd_out` is 1, `irq` is 0 and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock; one command-line bit per cycle |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | register write address |
| wr_data | input | 32 | register write data |
| rd_en | input | 1 | register read strobe (advances the response index on address 0) |
| rd_addr | input | 2 | register read address |
| rd_data | output | 32 | register read data, combinational |
| cmd_out | output | 1 | command line output value |
| cmd_oe | output | 1 | command line output enable |
| cmd_in | input | 1 | command line input from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| irq | output | 1 | command-done interrupt |

## Verification
The command path is driven with several command bytes and arguments. Two of the frames are compared against well-known literal frames, which separates a wrong CRC polynomial or bit order from a correct one. Short responses are sent four ways: clean, clean with the CRC check off, corrupted, and corrupted with the check off; together these separate the match flag from the error flag. The same long response is sent with and without the skip of the first 7 bits, and the expected flags show whether the CRC start point is honoured. Further tests cover a missing start bit, a held DAT0 and an abort in mid-frame; they pin down the cycle at which done appears and show that the engine really returns to idle.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TMO_CYCLES = 64,
  parameter int RESP_MAXW  = 136
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        irq
);
  localparam int SHW   = RESP_MAXW - 1;
  localparam int NWORD = (SHW - 7) / 32;
  localparam int IW    = $clog2(NWORD);
  localparam int TW    = $clog2(TMO_CYCLES);
  localparam int CW    = 9;
  localparam logic [1:0] A_ARG = 2'd0, A_SND = 2'd1, A_STA = 2'd2, A_CTL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY} st_t;

  st_t             state;
  logic [31:0]     arg_q, send_q;
  logic [39:0]     txsh;
  logic [6:0]      crc;
  logic [CW-1:0]   n;
  logic [TW-1:0]   w;
  logic [SHW-1:0]  shreg;
  logic [IW-1:0]   idx;
  logic            irq_en, done, tmo, crc_ok, crc_err;

  wire [7:0] rbits   = send_q[15:8];
  wire       resp_en = send_q[16];
  wire       no_crc  = send_q[17];
  wire       from8   = send_q[18];
  wire       bchk    = send_q[19];
  wire       go      = wr_en && wr_addr == A_SND && state == S_IDLE;
  wire       sreset  = wr_en && wr_addr == A_CTL && wr_data[1];
  wire [CW-1:0] skip = from8 ? CW'(7) : '0;
  wire       in_crc  = n >= skip && (n + CW'(7)) <= {1'b0, rbits};
  wire       busy    = state != S_IDLE;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  assign cmd_oe  = state == S_TX;
  assign cmd_out = (state != S_TX) ? 1'b1 :
                   (n < CW'(40))   ? txsh[39] :
                   (n < CW'(47))   ? crc[6] : 1'b1;
  assign irq     = done & irq_en;

  always_comb begin
    case (rd_addr)
      A_ARG:   rd_data = shreg[7 + 32*int'(idx) +: 32];
      A_SND:   rd_data = send_q;
      A_STA:   rd_data = {27'd0, done, tmo, crc_err, crc_ok, busy};
      default: rd_data = 32'(irq_en) | (32'(idx) << 8);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; arg_q <= '0; send_q <= '0; txsh <= '0; crc <= '0;
      n <= '0; w <= '0; shreg <= '0; idx <= '0; irq_en <= 1'b0;
      done <= 1'b0; tmo <= 1'b0; crc_ok <= 1'b0; crc_err <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_ARG) arg_q <= wr_data;
      if (wr_en && wr_addr == A_CTL) begin
        irq_en <= wr_data[0];
        idx    <= wr_data[8 +: IW];
      end else if (rd_en && rd_addr == A_ARG) begin
        idx <= idx + 1'b1;
      end
      if (wr_en && wr_addr == A_STA && wr_data[4]) done <= 1'b0;

      if (sreset) begin
        state <= S_IDLE; done <= 1'b0; tmo <= 1'b0;
        crc_ok <= 1'b0; crc_err <= 1'b0;
      end else if (go) begin
        send_q <= wr_data; txsh <= {wr_data[7:0], arg_q};
        crc <= '0; n <= '0; w <= '0; shreg <= '0;
        done <= 1'b0; tmo <= 1'b0; crc_ok <= 1'b0; crc_err <= 1'b0;
        state <= S_TX;
      end else begin
        case (state)
          S_TX: begin
            n <= n + 1'b1;
            if (n < CW'(40)) begin
              crc  <= crc7_step(crc, txsh[39]);
              txsh <= {txsh[38:0], 1'b0};
            end else if (n < CW'(47)) begin
              crc <= {crc[5:0], 1'b0};
            end else begin
              w <= '0;
              if (resp_en)   state <= S_WAIT;
              else if (bchk) state <= S_BUSY;
              else begin state <= S_IDLE; done <= 1'b1; end
            end
          end
          S_WAIT: begin
            if (!cmd_in) begin
              state <= S_RX; n <= '0; crc <= '0;
            end else if (w == TW'(TMO_CYCLES - 1)) begin
              tmo <= 1'b1; done <= 1'b1; state <= S_IDLE;
            end else begin
              w <= w + 1'b1;
            end
          end
          S_RX: begin
            if (n <= {1'b0, rbits}) begin
              shreg <= {shreg[SHW-2:0], cmd_in};
              if (in_crc) crc <= crc7_step(crc, cmd_in);
              n <= n + 1'b1;
            end else begin
              crc_ok  <= (crc == shreg[6:0]) && cmd_in;
              crc_err <= !((crc == shreg[6:0]) && cmd_in) && !no_crc;
              if (bchk) state <= S_BUSY;
              else begin state <= S_IDLE; done <= 1'b1; end
            end
          end
          S_BUSY: begin
            if (dat0_in) begin
              done <= 1'b1; state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> ($past(n) == CW'(47) || $past(sreset)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> state == S_IDLE);
  // R7
  timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (!crc_ok && !crc_err));
  // R5
  crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (!crc_ok && !no_crc));
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (state == S_IDLE && !done && !cmd_oe));
  // R10
  send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(send_q));
endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic cmd_out, cmd_oe, irq;
  logic cmd_in = 1'b1, dat0_in = 1'b1;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sd_cmd_engine i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in), .irq(irq));

  // cmd[7:0], arg[31:0], status[31:0], flags {corrupt, no_crc, resp}
  localparam logic [74:0] VEC [5] = '{
    {8'h40, 32'h0000_0000, 32'h0000_0000, 3'b000},
    {8'h48, 32'h0000_01AA, 32'h0000_01AA, 3'b001},
    {8'h51, 32'h1234_5678, 32'h0000_0900, 3'b101},
    {8'h77, 32'hDEAD_BEEF, 32'h0000_0120, 3'b111},
    {8'h7A, 32'h0000_0000, 32'h80FF_8000, 3'b011}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [135:0] v, input int nb);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(output logic [31:0] d);
    rd_addr = 2'd2;
    #1 d = rd_data;
  endtask

  task automatic send_cmd(input logic [31:0] a, input logic [31:0] s,
                          output logic [47:0] fr, output bit oe_ok);
    wr(2'd0, a);
    wr(2'd1, s);
    fr = '0; oe_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      if (!cmd_oe) oe_ok = 1'b0;
      fr = {fr[46:0], cmd_out};
      @(negedge clk);
    end
    if (cmd_oe) oe_ok = 1'b0;
  endtask

  task automatic drive_resp(input logic [135:0] f, input int len);
    cmd_in = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = f[i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] st, v, s;
    logic [47:0] fr, efr;
    logic [135:0] lf;
    logic [119:0] data;
    logic [6:0] c_skip, c_full;
    bit oe_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    peek(st);
    chk(st == 0, "R11 status", 64'(st), 0);
    chk(cmd_oe == 0, "R11 cmd_oe", 64'(cmd_oe), 0);
    chk(cmd_out == 1, "R11 cmd_out", 64'(cmd_out), 1);
    chk(irq == 0, "R11 irq", 64'(irq), 0);

    wr(2'd3, 32'h1);

    // R1 literal frames
    send_cmd(32'h0, 32'h40, fr, oe_ok);
    chk(fr == 48'h40_0000_0000_95, "R1 CMD0 frame", 64'(fr), 64'h40_0000_0000_95);
    chk(oe_ok, "R1 oe window CMD0", 64'(oe_ok), 1);
    wr(2'd2, 32'h10);
    send_cmd(32'h1AA, 32'h48, fr, oe_ok);
    chk(fr == 48'h48_0000_01AA_87, "R1 CMD8 frame", 64'(fr), 64'h48_0000_01AA_87);
    wr(2'd2, 32'h10);

    // vector table: short responses
    for (int k = 0; k < 5; k++) begin
      logic [7:0] c;
      logic [31:0] a, stv;
      logic rsp, nocrc, bad;
      logic [38:0] pl;
      logic [6:0] rc;
      logic [4:0] exp_st;
      {c, a, stv, bad, nocrc, rsp} = VEC[k];
      s = 32'(c) | (32'd45 << 8) | (32'(rsp) << 16) | (32'(nocrc) << 17);
      send_cmd(a, s, fr, oe_ok);
      efr = {c, a, bcrc(136'({c, a}), 40), 1'b1};
      chk(fr == efr, "R1 frame", 64'(fr), 64'(efr));
      chk(oe_ok, "R1 oe window", 64'(oe_ok), 1);
      if (rsp) begin
        pl = {1'b0, c[5:0], stv};
        rc = bcrc(136'(pl), 39) ^ (bad ? 7'h01 : 7'h00);
        drive_resp(136'({1'b0, pl, rc, 1'b1}), 48);
      end
      peek(st);
      exp_st = {1'b1, 1'b0, rsp & bad & ~nocrc, rsp & ~bad, 1'b0};
      chk(st[4:0] == exp_st, "R4 R5 status", 64'(st), 64'(exp_st));
      chk(irq == 1, "R8 irq raised", 64'(irq), 1);
      if (rsp) begin
        wr(2'd3, 32'h1);
        rd(2'd0, v);
        chk(v == stv, "R2 R3 short word", 64'(v), 64'(stv));
      end
      wr(2'd2, 32'h10);
      peek(st);
      chk(st[4] == 0 && irq == 0, "R8 done cleared", 64'({st[4], irq}), 0);
    end

    // long response, CRC from bit 8
    data = {24'hA1B2C3, 32'h11223344, 32'h55667788, 32'h99AABBCC};
    c_skip = bcrc(136'(data), 120);
    c_full = bcrc(136'({7'b0111111, data}), 127);
    lf = {1'b0, 7'b0111111, data, c_skip, 1'b1};
    s = 32'h42 | (32'd133 << 8) | (32'd1 << 16) | (32'd1 << 18);
    send_cmd(32'h0, s, fr, oe_ok);
    peek(st);
    chk(st[0] == 1, "R10 active", 64'(st), 1);
    wr(2'd1, 32'h41);
    rd(2'd1, v);
    chk(v == s, "R10 send ignored", 64'(v), 64'(s));
    drive_resp(lf, 136);
    peek(st);
    chk(st[4:0] == 5'b10010, "R4 long skip ok", 64'(st), 64'h12);
    wr(2'd3, 32'h1);
    rd(2'd0, v); chk(v == 32'h99AABBCC, "R3 word0", 64'(v), 64'h99AABBCC);
    rd(2'd0, v); chk(v == 32'h55667788, "R3 word1", 64'(v), 64'h55667788);
    rd(2'd0, v); chk(v == 32'h11223344, "R3 word2", 64'(v), 64'h11223344);
    rd(2'd0, v); chk(v == 32'h3FA1B2C3, "R3 word3", 64'(v), 64'h3FA1B2C3);
    wr(2'd3, 32'h201);
    rd(2'd0, v); chk(v == 32'h11223344, "R3 index 2", 64'(v), 64'h11223344);
    wr(2'd2, 32'h10);

    // same long response without the skip
    s = 32'h42 | (32'd133 << 8) | (32'd1 << 16);
    send_cmd(32'h0, s, fr, oe_ok);
    drive_resp(lf, 136);
    peek(st);
    chk(st[2] == (c_skip != c_full) && st[1] == (c_skip == c_full), "R4 long full",
        64'(st), 64'({c_skip != c_full, c_skip == c_full}));
    wr(2'd2, 32'h10);

    // R7 timeout
    s = 32'h4D | (32'd45 << 8) | (32'd1 << 16);
    send_cmd(32'h0, s, fr, oe_ok);
    repeat (63) @(negedge clk);
    peek(st);
    chk(st[4:0] == 5'b00001, "R7 before timeout", 64'(st), 1);
    @(negedge clk);
    peek(st);
    chk(st[4:0] == 5'b11000, "R7 timeout", 64'(st), 64'h18);
    wr(2'd2, 32'h10);

    // R6 busy wait
    dat0_in = 1'b0;
    s = 32'h4C | (32'd1 << 19);
    send_cmd(32'h0, s, fr, oe_ok);
    repeat (4) @(negedge clk);
    peek(st);
    chk(st[4:0] == 5'b00001, "R6 held busy", 64'(st), 1);
    dat0_in = 1'b1;
    @(negedge clk);
    peek(st);
    chk(st[4:0] == 5'b10000, "R6 released", 64'(st), 64'h10);
    wr(2'd2, 32'h10);

    // R9 abort mid-frame
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h51 | (32'd45 << 8) | (32'd1 << 16));
    repeat (3) @(negedge clk);
    chk(cmd_oe == 1, "R9 in frame", 64'(cmd_oe), 1);
    wr(2'd3, 32'h3);
    peek(st);
    chk(cmd_oe == 0 && cmd_out == 1, "R9 line released", 64'({cmd_oe, cmd_out}), 1);
    chk(st[4:0] == 0, "R9 status idle", 64'(st), 0);
    send_cmd(32'h0, 32'h40, fr, oe_ok);
    chk(fr == 48'h40_0000_0000_95, "R9 R1 restart", 64'(fr), 64'h40_0000_0000_95);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule